// File: doc/BRIEF.md
# Credit-Based Transmit Shaper Arbiter

This block chooses which of two transmit queues may send its next frame on an Ethernet port. One queue holds high-priority audio/video frames. The other holds best-effort legacy frames. All AV frames pass through a single credit-based shaper, and the stream classes inside the AV queue are not ranked against each other. A signed credit counter limits how much bandwidth AV traffic may take:

- The credit falls by a send slope while an AV frame is on the wire.
- It rises by an idle slope while AV traffic waits.
- It is emptied whenever the AV queue runs dry.

Decisions are made only between frames. A frame that has started is never interrupted. The MAC side signals the last byte of each granted frame with a one-cycle pulse. A byte-time enable sets the pace of every credit update.

The scheduler has three states:

- `ST_IDLE` is the frame boundary, where arbitration happens.
- `ST_AV_TX` means an AV frame holds the port.
- `ST_LEG_TX` means a legacy frame holds the port.

It has four transitions:

- `T_GRANT_AV` goes from `ST_IDLE` to `ST_AV_TX`.
- `T_GRANT_LEG` goes from `ST_IDLE` to `ST_LEG_TX`.
- `T_AV_DONE` goes from `ST_AV_TX` to `ST_IDLE` on the last-byte pulse.
- `T_LEG_DONE` goes from `ST_LEG_TX` to `ST_IDLE` on the last-byte pulse.

A typical setting uses an idle slope to send slope ratio of 3:1, which gives AV traffic 75 % of the link. It also sizes the upper limit for a 2000-byte envelope frame. Because the AV share stays below 100 %, legacy traffic always gets some bandwidth.

Top module: `cbs_tx_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, both grants are low, the credit is 0 and the scheduler is in `ST_IDLE`.
- R2: In `ST_IDLE`, if the AV queue is non-empty and the credit is at least 0, the next clock moves to `ST_AV_TX` (`T_GRANT_AV`) and `av_grant` goes high. This happens even when legacy traffic is also queued.
- R3: In `ST_IDLE`, if AV is not eligible (its queue is empty or the credit is negative) and legacy is queued, the next clock moves to `ST_LEG_TX` (`T_GRANT_LEG`) and `leg_grant` goes high.
- R4: A grant stays high, whatever the queue or credit inputs do, until a clock on which `frame_end` is 1. That clock returns the scheduler to `ST_IDLE` (`T_AV_DONE`/`T_LEG_DONE`), so there is one cycle with no grant before the next frame.
- R5: On a byte-enabled clock in `ST_AV_TX`, the credit decreases by `send_slope`.
- R6: On a byte-enabled clock outside `ST_AV_TX` with the AV queue non-empty, the credit increases by `idle_slope`. This is the case, for example, while AV waits behind a legacy frame.
- R7: On a byte-enabled clock outside `ST_AV_TX` with the AV queue empty, a positive credit is set to 0. A non-positive credit rises by `idle_slope` but never above 0.
- R8: After each update the credit is clamped to the range [`lo_limit`, `hi_limit`].
- R9: On clocks with `byte_en` low, the credit does not change.
- R10: `av_grant` and `leg_grant` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_en | input | 1 | Byte-time enable that paces credit updates |
| av_queued | input | 1 | AV queue holds at least one frame |
| leg_queued | input | 1 | Legacy queue holds at least one frame |
| frame_end | input | 1 | One-cycle pulse on the last byte of the granted frame |
| idle_slope | input | CW | Credit gain per byte time while AV waits (unsigned) |
| send_slope | input | CW | Credit loss per byte time while AV sends (unsigned magnitude) |
| hi_limit | input | CW | Upper credit bound (signed) |
| lo_limit | input | CW | Lower credit bound (signed) |
| av_grant | output | 1 | AV queue owns the port (`ST_AV_TX`) |
| leg_grant | output | 1 | Legacy queue owns the port (`ST_LEG_TX`) |
| credit | output | CW | Current shaper credit (signed) |

## Verification
A grant appears in the cycle after the clock edge at which `ST_IDLE` saw the queues and the credit. After a last-byte pulse, the grant drops on the next edge, and the earliest following grant comes one edge after that. A credit update is visible one edge after the byte-enabled clock that caused it, and it is based on the state the scheduler held before that edge. The bench drives inputs and samples outputs on the falling edge. A behavioural model, advanced on the rising edge, is compared with the design every cycle. Directed checks count edges along these same delays before they compare fixed values.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_AV_TX  = 2'd1,
        ST_LEG_TX = 2'd2
    } sched_state_t;

endpackage

// File: rtl/cbs_credit.sv
module cbs_credit #(
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_en,
    input  logic                 av_sending,
    input  logic                 av_queued,
    input  logic [CW-1:0]        idle_slope,
    input  logic [CW-1:0]        send_slope,
    input  logic signed [CW-1:0] hi_limit,
    input  logic signed [CW-1:0] lo_limit,
    output logic signed [CW-1:0] credit_q
);
    localparam int XW = CW + 2;

    logic signed [XW-1:0] cur_x, idle_x, send_x, hi_x, lo_x, raw, sat;

    always_comb begin
        cur_x  = XW'(credit_q);
        idle_x = $signed({2'b00, idle_slope});
        send_x = $signed({2'b00, send_slope});
        hi_x   = XW'(hi_limit);
        lo_x   = XW'(lo_limit);
        if (av_sending) begin
            raw = cur_x - send_x;
        end else if (av_queued) begin
            raw = cur_x + idle_x;
        end else if (cur_x > 0) begin
            raw = '0;
        end else begin
            raw = cur_x + idle_x;
            if (raw > 0) raw = '0;
        end
        sat = raw;
        if (sat > hi_x) sat = hi_x;
        if (sat < lo_x) sat = lo_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       credit_q <= '0;
        else if (byte_en) credit_q <= sat[CW-1:0];
    end

    AST_HOLD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> $stable(credit_q)); // R9

    AST_DRAIN_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && !av_sending && !av_queued && lo_limit <= 0) |=> (credit_q <= 0)); // R7

    AST_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && lo_limit <= hi_limit) |=>
        (credit_q <= $past(hi_limit) && credit_q >= $past(lo_limit))); // R8

endmodule

// File: rtl/cbs_sched_fsm.sv
module cbs_sched_fsm
    import cbs_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 av_queued,
    input  logic                 leg_queued,
    input  logic                 frame_end,
    input  logic signed [CW-1:0] credit,
    output logic                 av_grant,
    output logic                 leg_grant
);
    sched_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (av_queued && credit >= 0) state_d = ST_AV_TX;   // T_GRANT_AV
                else if (leg_queued)          state_d = ST_LEG_TX;  // T_GRANT_LEG
            end
            ST_AV_TX:  if (frame_end) state_d = ST_IDLE;            // T_AV_DONE
            ST_LEG_TX: if (frame_end) state_d = ST_IDLE;            // T_LEG_DONE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        av_grant  = (state_q == ST_AV_TX);
        leg_grant = (state_q == ST_LEG_TX);
    end

    AST_AV_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && av_queued && credit >= 0) |=> av_grant); // R2

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((av_grant || leg_grant) && !frame_end) |=> $stable(state_q)); // R4

    AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        ((av_grant || leg_grant) && frame_end) |=> (!av_grant && !leg_grant)); // R4

endmodule

// File: rtl/cbs_tx_arbiter.sv
module cbs_tx_arbiter #(
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_en,
    input  logic                 av_queued,
    input  logic                 leg_queued,
    input  logic                 frame_end,
    input  logic [CW-1:0]        idle_slope,
    input  logic [CW-1:0]        send_slope,
    input  logic signed [CW-1:0] hi_limit,
    input  logic signed [CW-1:0] lo_limit,
    output logic                 av_grant,
    output logic                 leg_grant,
    output logic signed [CW-1:0] credit
);
    cbs_sched_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .av_queued  (av_queued),
        .leg_queued (leg_queued),
        .frame_end  (frame_end),
        .credit     (credit),
        .av_grant   (av_grant),
        .leg_grant  (leg_grant)
    );

    cbs_credit #(.CW(CW)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (byte_en),
        .av_sending (av_grant),
        .av_queued  (av_queued),
        .idle_slope (idle_slope),
        .send_slope (send_slope),
        .hi_limit   (hi_limit),
        .lo_limit   (lo_limit),
        .credit_q   (credit)
    );

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(av_grant && leg_grant)); // R10

endmodule

// File: tb/test_cbs_tx_arbiter.sv
module test_cbs_tx_arbiter;
    localparam int CW = 32;

    logic clk = 0, rst_n = 0;
    logic byte_en = 0, av_queued = 0, leg_queued = 0, frame_end = 0;
    logic [CW-1:0] idle_slope = 3, send_slope = 1;
    logic signed [CW-1:0] hi_limit = 20, lo_limit = -30;
    logic av_grant, leg_grant;
    logic signed [CW-1:0] credit;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    int     m_state = 0;   // 0 idle, 1 av, 2 legacy
    longint m_credit = 0;

    always #4 clk = ~clk;

    cbs_tx_arbiter #(.CW(CW)) i_cbs_tx_arbiter (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .av_queued(av_queued),
        .leg_queued(leg_queued), .frame_end(frame_end), .idle_slope(idle_slope),
        .send_slope(send_slope), .hi_limit(hi_limit), .lo_limit(lo_limit),
        .av_grant(av_grant), .leg_grant(leg_grant), .credit(credit)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_credit = 0;
        end else begin
            longint nc;
            int ns;
            nc = m_credit;
            if (m_state == 1)       nc = m_credit - longint'(send_slope);
            else if (av_queued)     nc = m_credit + longint'(idle_slope);
            else if (m_credit > 0)  nc = 0;
            else begin
                nc = m_credit + longint'(idle_slope);
                if (nc > 0) nc = 0;
            end
            if (nc > longint'(hi_limit)) nc = hi_limit;
            if (nc < longint'(lo_limit)) nc = lo_limit;
            ns = m_state;
            if (m_state == 0) begin
                if (av_queued && m_credit >= 0) ns = 1;
                else if (leg_queued)            ns = 2;
            end else if (frame_end) ns = 0;
            if (byte_en) m_credit = nc;
            m_state = ns;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(av_grant == (m_state == 1), "R2 R3 R4 av_grant vs model", av_grant, m_state == 1);
            chk(leg_grant == (m_state == 2), "R2 R3 R4 leg_grant vs model", leg_grant, m_state == 2);
            chk(longint'(credit) == m_credit, "R5 R6 R7 R8 R9 credit vs model", credit, m_credit);
            chk(!(av_grant && leg_grant), "R10 exclusive grants", av_grant && leg_grant, 0);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        longint c0;
        repeat (3) @(negedge clk);
        chk(av_grant == 0 && leg_grant == 0, "R1 grants in reset", av_grant | leg_grant, 0);
        chk(credit == 0, "R1 credit in reset", credit, 0);
        rst_n = 1;
        @(negedge clk);
        chk(credit == 0 && !av_grant && !leg_grant, "R1 after release", credit, 0);

        // legacy alone
        byte_en = 1; leg_queued = 1;
        @(negedge clk);
        chk(leg_grant == 1, "R3 legacy granted with AV empty", leg_grant, 1);

        // byte_en low: credit frozen, grant held
        byte_en = 0; av_queued = 1;
        repeat (4) @(negedge clk);
        chk(credit == 0, "R9 credit frozen without byte_en", credit, 0);
        chk(leg_grant == 1 && av_grant == 0, "R4 no preemption by AV", av_grant, 0);

        // AV waits behind legacy frame: rises and clamps
        byte_en = 1;
        @(negedge clk);
        chk(credit == 3, "R6 credit rises while AV waits", credit, 3);
        repeat (9) @(negedge clk);
        chk(credit == 20, "R8 credit clamped at hi_limit", credit, 20);

        // legacy frame ends; gap; AV wins over queued legacy
        frame_end = 1;
        @(negedge clk);
        frame_end = 0;
        chk(!av_grant && !leg_grant, "R4 idle gap after frame end", av_grant | leg_grant, 0);
        @(negedge clk);
        chk(av_grant == 1, "R2 AV has priority with credit >= 0", av_grant, 1);
        repeat (5) @(negedge clk);
        chk(credit == 15, "R5 credit drops during AV frame", credit, 15);
        repeat (45) @(negedge clk);
        chk(credit == -30, "R8 credit clamped at lo_limit", credit, -30);

        // AV frame ends with negative credit: legacy goes
        frame_end = 1;
        @(negedge clk);
        frame_end = 0;
        @(negedge clk);
        chk(leg_grant == 1 && av_grant == 0, "R3 legacy granted while credit negative", leg_grant, 1);
        c0 = credit;
        @(negedge clk);
        chk(longint'(credit) == c0 + 3, "R6 credit rises behind legacy", credit, c0 + 3);

        // AV queue empties: negative credit recovers only to zero
        av_queued = 0;
        repeat (12) @(negedge clk);
        chk(credit == 0, "R7 negative credit recovers to zero", credit, 0);

        // build positive credit, then empty the queue
        av_queued = 1;
        repeat (3) @(negedge clk);
        chk(credit == 9, "R6 credit builds to 9", credit, 9);
        av_queued = 0;
        @(negedge clk);
        chk(credit == 0, "R7 positive credit discarded", credit, 0);

        // toggling byte_en during an AV frame
        av_queued = 1; frame_end = 1;
        @(negedge clk);
        frame_end = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            byte_en = i[0];
            @(negedge clk);
        end
        byte_en = 1; av_queued = 0; leg_queued = 0; frame_end = 1;
        @(negedge clk);
        frame_end = 0;
        repeat (10) @(negedge clk);
        chk(!av_grant && !leg_grant, "R4 idle with empty queues", av_grant | leg_grant, 0);
        finish_run();
    end
endmodule